// File: doc/BRIEF.md
# Block Copy Micro-op Generator

This block sequences the operations for a repeated memory-copy instruction without using any branch operations. When a start is accepted, it first issues one operation that asks the back-end to report the live count register. It then issues a fixed first batch of copy operations without waiting for that count. The batch is sized so that it spans 96 bytes at the element size given at start. Until the count is known, the back-end resolves each copy operation's predicate itself. Once the count has been captured, every copy operation the block emits carries a resolved predicate. If the count is larger than the batch, the block follows the batch with exactly the extra copy operations still needed.

The issue stage applies backpressure through a ready input, and the block holds its current operation for as long as ready is low. A single-cycle done pulse ends each sequence. With it comes a slow-path flag that marks a zero count, or a count too large for the first batch. A flush abandons the sequence at any time. A start that arrives while a sequence is in progress is ignored. Memory accesses and the architectural update of pointers and count happen elsewhere.

Top module: `blkcp_gen`

## Requirements
- R1: After reset, op_vld_o and done_o are 0 until a start is accepted.
- R2: A start accepted while idle (no flush in that cycle) makes the next presented operation a count-report request (op_kind_o = 1). Exactly one request is issued per sequence.
- R3: After the request, the block presents copy operations (op_kind_o = 0) with indices 0, 1, 2, … in order. The first batch holds n = 96 / 2^esz_i operations, with esz_i encoded 0 = 1 byte, 1 = 2, 2 = 4, 3 = 8 (n = 96, 48, 24, 12). The whole batch is issued whatever the count turns out to be.
- R4: While the count is not yet captured, a copy operation shows op_pred_ok_o = 0 and op_pred_o = 0. Once it is captured, op_pred_ok_o = 1 and op_pred_o = 1 exactly when op_idx_o < count, including for batch operations that are still pending.
- R5: When count > n, indices n through count-1 follow the batch, each with op_pred_ok_o = 1 and op_pred_o = 1. No other operation kinds and no further requests are issued. When count <= n, nothing follows the batch.
- R6: While op_vld_o is 1 and issue_rdy_i is 0, the presented op_kind_o and op_idx_o stay unchanged.
- R7: done_o is high for exactly one cycle, with op_vld_o low. That cycle follows the acceptance of the last operation, or follows the count's capture if every operation was already accepted.
- R8: During done_o, slow_o is 1 exactly when count = 0 or count > n.
- R9: A start while a sequence is in progress is ignored. Neither the element size nor the index stream changes.
- R10: flush_i returns the block to idle at the next edge: op_vld_o and done_o are 0 from the next cycle until a new start.
- R11: A count return is captured only when a sequence is in progress, its request has been accepted, and no count has been captured yet. Count returns at any other time have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Abandon the current sequence |
| start_i | input | 1 | Start a copy sequence |
| esz_i | input | 2 | Element size code sampled at start (log2 bytes) |
| cnt_vld_i | input | 1 | Count return valid |
| cnt_i | input | CNT_W | Count value returned by the back-end |
| issue_rdy_i | input | 1 | Issue stage accepts the presented operation |
| op_vld_o | output | 1 | Operation presented |
| op_kind_o | output | 1 | 0 = copy, 1 = count-report request |
| op_idx_o | output | CNT_W | Copy iteration index (0 for the request) |
| op_pred_o | output | 1 | Resolved predicate: iteration is live |
| op_pred_ok_o | output | 1 | Predicate has been resolved by the block |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| slow_o | output | 1 | Zero or extended count, valid with done_o |

## Verification
Several properties are checked on every cycle. The request is the first operation after an accepted start. Accepted copy operations step the index by one. An unresolved predicate is never set, and tail operations are always live. A stalled operation holds steady. The done pulse lasts one cycle and never overlaps an operation, and a flush empties the output. The total number of operations, the predicate value against each count, the exact cycle of done, the slow flag, and the effect of ignored starts and stray count returns can only be shown by the bench. It sweeps every element size, counts around zero and the batch edge, three moments of count arrival, and with and without backpressure.

// File: rtl/blkcp_pkg.sv
package blkcp_pkg;

  typedef enum logic {
    OPK_COPY   = 1'b0,
    OPK_CNTREQ = 1'b1
  } opk_e;

  // First-batch length in elements: bytes covered divided by element size.
  function automatic int unsigned batch_len(input int unsigned bytes,
                                            input logic [1:0] esz);
    return bytes >> esz;
  endfunction

  // Extended path: zero count, or count beyond what the batch covers.
  function automatic logic is_slow(input int unsigned cnt,
                                   input int unsigned n);
    return (cnt == 0) || (cnt > n);
  endfunction

endpackage

// File: rtl/blkcp_cnt_latch.sv
module blkcp_cnt_latch #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cap_en,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             known_o,
  output logic [CNT_W-1:0] cnt_o
);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      known_o <= 1'b0;
      cnt_o   <= '0;
    end else if (cap_en && !known_o) begin
      known_o <= 1'b1;
      cnt_o   <= cnt_i;
    end
  end

endmodule

// File: rtl/blkcp_idx_ctr.sv
module blkcp_idx_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] idx_o
);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) idx_o <= '0;
    else if (inc)      idx_o <= idx_o + 1'b1;
  end

endmodule

// File: rtl/blkcp_gen.sv
module blkcp_gen
  import blkcp_pkg::*;
#(
  parameter int BATCH_BYTES = 96,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             start_i,
  input  logic [1:0]       esz_i,
  input  logic             cnt_vld_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             issue_rdy_i,
  output logic             op_vld_o,
  output logic             op_kind_o,
  output logic [CNT_W-1:0] op_idx_o,
  output logic             op_pred_o,
  output logic             op_pred_ok_o,
  output logic             done_o,
  output logic             slow_o
);

  localparam logic [CNT_W-1:0] BATCH_MAX = CNT_W'(BATCH_BYTES);

  // Control state
  logic             busy;
  logic             req_sent;
  logic [CNT_W-1:0] batch_n;

  // Named internal events
  logic             start_acc;
  logic             cap_en;
  logic             cnt_known;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] idx;
  logic             in_batch;
  logic             in_tail;
  logic             below_cnt;
  logic             fin;
  logic             acc;
  logic             idx_clr;
  logic             idx_inc;
  opk_e             kind;

  assign start_acc = start_i && !busy && !flush_i;
  assign cap_en    = busy && req_sent && cnt_vld_i && !flush_i;
  assign below_cnt = idx < cnt_q;
  assign in_batch  = idx < batch_n;
  assign in_tail   = cnt_known && below_cnt && !in_batch;
  assign fin       = busy && req_sent && !in_batch && cnt_known && !below_cnt;
  assign op_vld_o  = busy && (!req_sent || in_batch || in_tail);
  assign acc       = op_vld_o && issue_rdy_i;
  assign idx_clr   = start_acc || flush_i;
  assign idx_inc   = acc && req_sent && !flush_i;

  blkcp_cnt_latch #(.CNT_W(CNT_W)) cnt_latch_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (idx_clr),
    .cap_en  (cap_en),
    .cnt_i   (cnt_i),
    .known_o (cnt_known),
    .cnt_o   (cnt_q)
  );

  blkcp_idx_ctr #(.CNT_W(CNT_W)) idx_ctr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (idx_clr),
    .inc   (idx_inc),
    .idx_o (idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      req_sent <= 1'b0;
      batch_n  <= BATCH_MAX;
    end else if (flush_i) begin
      busy     <= 1'b0;
      req_sent <= 1'b0;
    end else if (start_acc) begin
      busy     <= 1'b1;
      req_sent <= 1'b0;
      batch_n  <= CNT_W'(batch_len(BATCH_BYTES, esz_i));
    end else begin
      if (acc && !req_sent) req_sent <= 1'b1;
      if (fin)              busy     <= 1'b0;
    end
  end

  // Operation formatting
  always_comb begin
    kind         = req_sent ? OPK_COPY : OPK_CNTREQ;
    op_kind_o    = kind;
    op_idx_o     = req_sent ? idx : '0;
    op_pred_ok_o = req_sent && cnt_known;
    op_pred_o    = req_sent && cnt_known && below_cnt;
  end

  assign done_o = fin;
  assign slow_o = fin && is_slow(int'(cnt_q), int'(batch_n));

endmodule

// File: rtl/blkcp_gen_chk.sv
module blkcp_gen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush_i,
  input logic             start_i,
  input logic             issue_rdy_i,
  input logic             busy,
  input logic [CNT_W-1:0] batch_n,
  input logic             op_vld_o,
  input logic             op_kind_o,
  input logic [CNT_W-1:0] op_idx_o,
  input logic             op_pred_o,
  input logic             op_pred_ok_o,
  input logic             done_o
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy) |-> (!op_vld_o && !done_o));

  a_r2_req_first: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy && !flush_i) |=> (op_vld_o && op_kind_o));

  a_r3_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (op_vld_o && issue_rdy_i && !op_kind_o && !flush_i)
      |=> (!op_vld_o || (op_idx_o == $past(op_idx_o) + 1'b1)));

  a_r4_unresolved_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (op_vld_o && !op_pred_ok_o) |-> !op_pred_o);

  a_r5_tail_live: assert property (@(posedge clk) disable iff (!rst_n)
    (op_vld_o && !op_kind_o && (op_idx_o >= batch_n)) |-> (op_pred_ok_o && op_pred_o));

  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op_vld_o && !issue_rdy_i && !flush_i)
      |=> (op_vld_o && $stable(op_kind_o) && $stable(op_idx_o)));

  a_r7_done_once: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r7_done_no_op: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !op_vld_o);

  a_r10_flush_idle: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (!op_vld_o && !done_o));

endmodule

bind blkcp_gen blkcp_gen_chk #(.CNT_W(CNT_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .flush_i      (flush_i),
  .start_i      (start_i),
  .issue_rdy_i  (issue_rdy_i),
  .busy         (busy),
  .batch_n      (batch_n),
  .op_vld_o     (op_vld_o),
  .op_kind_o    (op_kind_o),
  .op_idx_o     (op_idx_o),
  .op_pred_o    (op_pred_o),
  .op_pred_ok_o (op_pred_ok_o),
  .done_o       (done_o)
);

// File: tb/blkcp_gen_tb.sv
module blkcp_gen_tb_top;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush_i = 1'b0;
  logic          start_i = 1'b0;
  logic [1:0]    esz_i = 2'd0;
  logic          cnt_vld_i = 1'b0;
  logic [CW-1:0] cnt_i = '0;
  logic          issue_rdy_i = 1'b0;
  logic          op_vld_o, op_kind_o, op_pred_o, op_pred_ok_o, done_o, slow_o;
  logic [CW-1:0] op_idx_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  blkcp_gen #(.BATCH_BYTES(96), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .start_i(start_i),
    .esz_i(esz_i), .cnt_vld_i(cnt_vld_i), .cnt_i(cnt_i),
    .issue_rdy_i(issue_rdy_i), .op_vld_o(op_vld_o), .op_kind_o(op_kind_o),
    .op_idx_o(op_idx_o), .op_pred_o(op_pred_o), .op_pred_ok_o(op_pred_ok_o),
    .done_o(done_o), .slow_o(slow_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One full sequence. cnt_at: copy ops accepted before the count is returned.
  // busy_pokes: backpressure, a start while busy, and stray count returns.
  task automatic do_run(input int esz, input int cnt, input int cnt_at, input bit busy_pokes);
    int  n, total, exp_idx, cyc, prev_idx, prev_kind;
    bit  known, req_done, finished, stall_prev, gave, accepted, spur_done, rdy;
    n        = 96 / (1 << esz);
    total    = (cnt > n) ? cnt : n;
    known    = 0; req_done = 0; exp_idx = 0; finished = 0;
    stall_prev = 0; spur_done = 0; prev_idx = 0; prev_kind = 0;

    @(negedge clk);
    start_i = 1'b1; esz_i = 2'(esz);
    if (busy_pokes) begin cnt_vld_i = 1'b1; cnt_i = CW'(cnt + 9); end  // R11 idle return
    @(negedge clk);
    start_i = 1'b0; cnt_vld_i = 1'b0;
    cyc = 0;
    while (!finished && cyc < 2000) begin
      if (done_o) begin
        chk(req_done && known && exp_idx == total, "R7 done after last op", exp_idx, total);
        chk(!op_vld_o, "R7 no op with done", op_vld_o, 0);
        chk(slow_o == ((cnt == 0) || (cnt > n)), "R8 slow flag", slow_o, int'((cnt == 0) || (cnt > n)));
        finished = 1;
      end else begin
        if (req_done && known && exp_idx >= total)
          chk(0, "R7 done missing", done_o, 1);
        if (op_vld_o) begin
          if (stall_prev)
            chk(op_idx_o == prev_idx && op_kind_o == prev_kind, "R6 stall hold", op_idx_o, prev_idx);
          if (!req_done) begin
            chk(op_kind_o == 1'b1, "R2 request first", op_kind_o, 1);
          end else begin
            chk(op_kind_o == 1'b0, "R5 copy kind only", op_kind_o, 0);
            chk(op_idx_o == exp_idx, "R3 index order", op_idx_o, exp_idx);
            chk(op_pred_ok_o == known, "R4 predicate resolved", op_pred_ok_o, known);
            chk(op_pred_o == (known && exp_idx < cnt), "R4 predicate value", op_pred_o,
                int'(known && exp_idx < cnt));
          end
        end else if (!(req_done && exp_idx >= n && !known)) begin
          chk(0, "R3 unexpected bubble", exp_idx, total);
        end
      end
      if (!finished) begin
        rdy  = busy_pokes ? ((cyc % 3) != 1) : 1'b1;
        issue_rdy_i = rdy;
        gave = 0;
        if (!known && req_done && exp_idx >= cnt_at) begin
          cnt_vld_i = 1'b1; cnt_i = CW'(cnt); gave = 1;
        end else if (busy_pokes && known && !spur_done) begin
          cnt_vld_i = 1'b1; cnt_i = CW'(cnt + 5); spur_done = 1;  // R11 second return
        end
        if (busy_pokes && cyc == 4) begin start_i = 1'b1; esz_i = ~2'(esz); end  // R9
        accepted   = op_vld_o && rdy;
        stall_prev = op_vld_o && !rdy;
        prev_idx   = op_idx_o;
        prev_kind  = op_kind_o;
        @(posedge clk);
        if (accepted) begin
          if (!req_done) req_done = 1; else exp_idx++;
        end
        if (gave) known = 1;
        @(negedge clk);
        start_i = 1'b0; cnt_vld_i = 1'b0; esz_i = 2'(esz);
        cyc++;
      end
    end
    if (!finished) chk(0, "R7 run watchdog", cyc, 2000);
    @(negedge clk);
    chk(!done_o && !op_vld_o, "R7 single done pulse", done_o, 0);
    issue_rdy_i = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL global watchdog actual=1 expected=0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!op_vld_o && !done_o, "R1 in reset", op_vld_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!op_vld_o && !done_o, "R1 idle after reset", op_vld_o, 0);

    // R10: flush mid-batch, then idle until the next start
    issue_rdy_i = 1'b1; start_i = 1'b1; esz_i = 2'd3;
    @(negedge clk); start_i = 1'b0;
    repeat (5) @(negedge clk);
    chk(op_vld_o, "R10 running before flush", op_vld_o, 1);
    flush_i = 1'b1;
    @(negedge clk); flush_i = 1'b0;
    chk(!op_vld_o && !done_o, "R10 flush to idle", op_vld_o, 0);
    repeat (3) @(negedge clk);
    chk(!op_vld_o && !done_o, "R10 stays idle", op_vld_o, 0);
    issue_rdy_i = 1'b0;

    for (int e = 0; e < 4; e++) begin
      for (int c = 0; c < 7; c++) begin
        for (int a = 0; a < 3; a++) begin
          for (int p = 0; p < 2; p++) begin
            int n, cnt, at;
            n = 96 >> e;
            case (c)
              0: cnt = 0;
              1: cnt = 1;
              2: cnt = 3;
              3: cnt = n - 1;
              4: cnt = n;
              5: cnt = n + 1;
              default: cnt = n + 7;
            endcase
            at = (a == 0) ? 0 : (a == 1) ? n / 2 : n;
            do_run(e, cnt, at, p[0]);
          end
        end
      end
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule